// File: doc/BRIEF.md
# Configurable Asynchronous Frame Receiver

This block turns an asynchronous serial line into received data words. A baud generator outside the block supplies a tick at sixteen times the bit rate. The receiver uses that tick to find a falling start edge, confirm the start bit at the middle of its bit time, and then sample every later bit at its midpoint. The frame format is set by a group of mode inputs. The data field holds 5 to 8 bits, sent least significant bit first. An optional extra bit follows the data, then an optional parity bit, then one or two stop bits. The receiver copies the mode inputs when it accepts a start edge, so a change to the mode during a frame has no effect on that frame.

When the final stop bit has been sampled, the block updates its result outputs together. These are the aligned data word, the captured extra bit, a parity-error flag and a framing-error flag. It then decides whether to pulse the receive-complete strobe. In multiprocessor mode the strobe is raised only when the extra bit is 1. A node can therefore ignore data frames and react only to address frames.

Top module: `uart_frame_rx`

## Requirements
- R1: The data-length field `cfg_len` selects 5 bits (00), 6 (01), 7 (10) or 8 (11). Bits arrive least significant first, and `rx_data` bits above the selected length read 0.
- R2: With `cfg_par_en`=1, a parity bit follows the data and extra bits. Its expected value depends on `cfg_ptype`. For 00 (odd) it is the inverted XOR of the data bits. For 01 (even) it is the XOR of the data bits. For 10 (mark) it is 1, and for 11 (space) it is 0. `par_err` is 1 exactly when the received bit differs from that value. With `cfg_par_en`=0 no parity bit is expected and `par_err` is 0.
- R3: With `cfg_xbit_en`=1, one extra bit follows the data field and is presented on `rx_xbit`. With `cfg_xbit_en`=0, `rx_xbit` is 0.
- R4: A frame starts only on a high-to-low transition of the line seen on a tick. If the line is high again at the middle of the start bit, the receiver returns to idle and reports nothing. A line held low after a frame does not start another frame.
- R5: If any stop bit is sampled as 0, `frm_err` is set for that frame and `rx_done` is not pulsed.
- R6: With multiprocessor filtering inactive, `rx_done` pulses for exactly one cycle at the end of every frame whose stop bits are all 1, whatever the parity result.
- R7: Multiprocessor filtering is active when `cfg_mp_en`=1, `cfg_xbit_en`=1 and `cfg_par_en`=0. While it is active, `rx_done` additionally requires the extra bit to be 1. When parity is enabled, `cfg_mp_en` has no effect.
- R8: `cfg_stop_long`=1 requests two stop bits for 6, 7 or 8 data bits. With 5 data bits the frame ends after one stop bit, so a start bit may follow that single stop bit directly.
- R9: After reset, `rx_data`, `rx_xbit`, `par_err`, `frm_err` and `rx_done` are 0.
- R10: The result outputs change only at the end of a frame, and they hold their values through idle time and aborted starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length select |
| cfg_ptype | input | 2 | Parity type select |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_xbit_en | input | 1 | Extra bit present |
| cfg_mp_en | input | 1 | Multiprocessor filtering request |
| cfg_stop_long | input | 1 | Two stop bits request |
| rx_data | output | 8 | Received data, right aligned |
| rx_xbit | output | 1 | Received extra bit |
| par_err | output | 1 | Parity mismatch in last frame |
| frm_err | output | 1 | Stop bit sampled low in last frame |
| rx_done | output | 1 | One-cycle receive-complete strobe |

## Verification
A wrong bit counter or a wrong frame-state sequence appears at the ports within one frame. The data bits come out shifted or truncated, or a stop-bit sample falls on a data bit and raises `frm_err` at the end of that same frame. A wrong decision to re-arm after a frame is harder to see. It shows up one frame later, as a corrupted word or a missing strobe after a break or after back-to-back frames. A broken filtering rule changes only the count of `rx_done` pulses per frame. For that reason the strobes are counted over every frame rather than just sampled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAX_BITS = 8;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] ptype;
    logic       par_en;
    logic       xbit_en;
    logic       mp_en;
    logic       stop_long;
  } rx_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_XBIT,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  localparam logic [1:0] PT_ODD   = 2'd0;
  localparam logic [1:0] PT_EVEN  = 2'd1;
  localparam logic [1:0] PT_MARK  = 2'd2;

  // number of data bits for a length code
  function automatic logic [3:0] bits_of(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // parity bit the sender must have placed on the line
  function automatic logic want_parity(input logic [1:0] pt,
                                       input logic [MAX_BITS-1:0] d);
    case (pt)
      PT_ODD:  return ~(^d);
      PT_EVEN: return ^d;
      PT_MARK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      assign ff_d = d;
    end else begin : g_chain
      assign ff_d = {ff_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{IDLE_VAL}};
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/uart_rx_bitclk.sv
module uart_rx_bitclk #(
  parameter int OS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic half,
  output logic strobe
);

  localparam int            CW       = $clog2(OS);
  localparam logic [CW-1:0] FULL_LIM = CW'(OS - 1);
  localparam logic [CW-1:0] HALF_LIM = CW'(OS / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  assign lim    = half ? HALF_LIM : FULL_LIM;
  assign strobe = tick && !restart && (cnt_q == lim);
  assign cnt_en = restart || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)           cnt_d = '0;
    else if (cnt_q == lim) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxs,
  input  logic                strobe,
  input  rx_cfg_t             cfg,
  output logic                restart,
  output logic                half,
  output logic                frame_end,
  output rx_cfg_t             cfg_q,
  output logic [MAX_BITS-1:0] sh_q,
  output logic                xb_q,
  output logic                pb_q,
  output logic                stop_bad
);

  rx_state_e           state_q, state_d;
  rx_cfg_t             cfg_d;
  logic [2:0]          bitn_q, bitn_d;
  logic [MAX_BITS-1:0] sh_d;
  logic                xb_d, pb_d;
  logic                bad_q, bad_d;
  logic                armed_q, armed_d;
  logic [3:0]          nb_m1;
  logic                last_bit;
  logic                long_eff;
  rx_state_e           after_data;
  rx_state_e           after_xbit;

  assign nb_m1      = bits_of(cfg_q.len) - 4'd1;
  assign last_bit   = ({1'b0, bitn_q} == nb_m1);
  assign long_eff   = cfg_q.stop_long && (cfg_q.len != 2'd0);
  assign after_xbit = cfg_q.par_en ? ST_PAR : ST_STOP1;
  assign after_data = cfg_q.xbit_en ? ST_XBIT : after_xbit;
  assign half       = (state_q == ST_START);
  assign stop_bad   = bad_q | ~rxs;

  always_comb begin
    state_d   = state_q;
    cfg_d     = cfg_q;
    bitn_d    = bitn_q;
    sh_d      = sh_q;
    xb_d      = xb_q;
    pb_d      = pb_q;
    bad_d     = bad_q;
    armed_d   = armed_q;
    restart   = 1'b0;
    frame_end = 1'b0;
    case (state_q)
      ST_IDLE: begin
        armed_d = armed_q | rxs;
        if (tick && armed_q && !rxs) begin
          state_d = ST_START;
          restart = 1'b1;
          cfg_d   = cfg;
          bitn_d  = '0;
          sh_d    = '0;
          xb_d    = 1'b0;
          pb_d    = 1'b0;
          bad_d   = 1'b0;
          armed_d = 1'b0;
        end
      end
      ST_START: begin
        if (strobe) state_d = rxs ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (strobe) begin
          sh_d = {rxs, sh_q[MAX_BITS-1:1]};
          if (last_bit) state_d = after_data;
          else          bitn_d  = bitn_q + 3'd1;
        end
      end
      ST_XBIT: begin
        if (strobe) begin
          xb_d    = rxs;
          state_d = after_xbit;
        end
      end
      ST_PAR: begin
        if (strobe) begin
          pb_d    = rxs;
          state_d = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (strobe) begin
          bad_d = stop_bad;
          if (long_eff) begin
            state_d = ST_STOP2;
          end else begin
            state_d   = ST_IDLE;
            frame_end = 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (strobe) begin
          bad_d     = stop_bad;
          state_d   = ST_IDLE;
          frame_end = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      xb_q    <= 1'b0;
      pb_q    <= 1'b0;
      bad_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      xb_q    <= xb_d;
      pb_q    <= pb_d;
      bad_q   <= bad_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/uart_rx_judge.sv
module uart_rx_judge
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  rx_cfg_t             cfg_q,
  input  logic [MAX_BITS-1:0] sh_q,
  input  logic                xb_q,
  input  logic                pb_q,
  input  logic                stop_bad,
  input  logic                mp_act,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_xbit,
  output logic                par_err,
  output logic                frm_err,
  output logic                rx_done
);

  logic [MAX_BITS-1:0] aligned;
  logic                xbit_d;
  logic                perr_d;
  logic                done_d;

  assign aligned = sh_q >> (4'(MAX_BITS) - bits_of(cfg_q.len));
  assign xbit_d  = cfg_q.xbit_en & xb_q;
  assign perr_d  = cfg_q.par_en & (pb_q != want_parity(cfg_q.ptype, aligned));
  assign done_d  = frame_end & ~stop_bad & (~mp_act | xb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_xbit <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else if (frame_end) begin
      rx_data <= aligned;
      rx_xbit <= xbit_d;
      par_err <= perr_d;
      frm_err <= stop_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_done <= 1'b0;
    else        rx_done <= done_d;
  end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rxd,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_ptype,
  input  logic                cfg_par_en,
  input  logic                cfg_xbit_en,
  input  logic                cfg_mp_en,
  input  logic                cfg_stop_long,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_xbit,
  output logic                par_err,
  output logic                frm_err,
  output logic                rx_done
);

  rx_cfg_t             cfg_live;
  rx_cfg_t             cfg_q;
  logic                rxs;
  logic                strobe;
  logic                restart;
  logic                half;
  logic                frame_end;
  logic [MAX_BITS-1:0] sh_q;
  logic                xb_q;
  logic                pb_q;
  logic                stop_bad;
  logic                mp_act;

  // frame-latched mode, also observed by the bound checker
  logic [1:0]          lat_len;
  logic                lat_par_en;
  logic                lat_xbit_en;

  assign cfg_live = '{len: cfg_len, ptype: cfg_ptype, par_en: cfg_par_en,
                      xbit_en: cfg_xbit_en, mp_en: cfg_mp_en,
                      stop_long: cfg_stop_long};

  assign mp_act      = cfg_q.mp_en & cfg_q.xbit_en & ~cfg_q.par_en;
  assign lat_len     = cfg_q.len;
  assign lat_par_en  = cfg_q.par_en;
  assign lat_xbit_en = cfg_q.xbit_en;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (rxs)
  );

  uart_rx_bitclk #(.OS(OS)) i_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (os_tick),
    .restart (restart),
    .half    (half),
    .strobe  (strobe)
  );

  uart_rx_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rxs       (rxs),
    .strobe    (strobe),
    .cfg       (cfg_live),
    .restart   (restart),
    .half      (half),
    .frame_end (frame_end),
    .cfg_q     (cfg_q),
    .sh_q      (sh_q),
    .xb_q      (xb_q),
    .pb_q      (pb_q),
    .stop_bad  (stop_bad)
  );

  uart_rx_judge i_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .cfg_q     (cfg_q),
    .sh_q      (sh_q),
    .xb_q      (xb_q),
    .pb_q      (pb_q),
    .stop_bad  (stop_bad),
    .mp_act    (mp_act),
    .rx_data   (rx_data),
    .rx_xbit   (rx_xbit),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .rx_done   (rx_done)
  );

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
  import uart_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_xbit,
  input logic                par_err,
  input logic                frm_err,
  input logic                rx_done,
  input logic [1:0]          lat_len,
  input logic                lat_par_en,
  input logic                lat_xbit_en,
  input logic                mp_act
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ((rx_data >> bits_of(lat_len)) == '0));

  assert_no_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !lat_par_en) |-> !par_err);

  assert_no_xbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !lat_xbit_en) |-> !rx_xbit);

  assert_done_clean_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !frm_err);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && mp_act) |-> rx_xbit);

endmodule

bind uart_frame_rx uart_frame_rx_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_data     (rx_data),
  .rx_xbit     (rx_xbit),
  .par_err     (par_err),
  .frm_err     (frm_err),
  .rx_done     (rx_done),
  .lat_len     (lat_len),
  .lat_par_en  (lat_par_en),
  .lat_xbit_en (lat_xbit_en),
  .mp_act      (mp_act)
);

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;

  localparam int BIT_CYC = 32;   // 16 ticks, one tick every second cycle

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic [1:0] m_len;
  logic [1:0] m_pt;
  logic       m_pe, m_xe, m_mp, m_sl;
  logic [7:0] rx_data;
  logic       rx_xbit, par_err, frm_err, rx_done;

  int checks;
  int errors;
  int done_cnt;
  bit finished;

  uart_frame_rx i_uart_frame_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .os_tick       (os_tick),
    .rxd           (rxd),
    .cfg_len       (m_len),
    .cfg_ptype     (m_pt),
    .cfg_par_en    (m_pe),
    .cfg_xbit_en   (m_xe),
    .cfg_mp_en     (m_mp),
    .cfg_stop_long (m_sl),
    .rx_data       (rx_data),
    .rx_xbit       (rx_xbit),
    .par_err       (par_err),
    .frm_err       (frm_err),
    .rx_done       (rx_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
    if (rst_n && rx_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic xon,
                            input logic xb, input logic pon, input logic pb,
                            input int nstop, input logic s1, input logic s2);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (xon) send_bit(xb);
    if (pon) send_bit(pb);
    send_bit(s1);
    if (nstop > 1) send_bit(s2);
  endtask

  function automatic logic par_bit(input logic [1:0] pt, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (pt)
      2'd0:    return (ones % 2) == 0;
      2'd1:    return (ones % 2) == 1;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic expect_out(input string req, input logic [7:0] ed, input logic ex,
                            input logic ep, input logic ef, input int edone, input int base);
    check(req, "rx_data", int'(rx_data), int'(ed));
    check(req, "rx_xbit", int'(rx_xbit), int'(ex));
    check(req, "par_err", int'(par_err), int'(ep));
    check(req, "frm_err", int'(frm_err), int'(ef));
    check(req, "rx_done count", done_cnt - base, edone);
  endtask

  task automatic set_mode(input logic [1:0] l, input logic [1:0] pt, input logic pe,
                          input logic xe, input logic mp, input logic sl);
    m_len = l; m_pt = pt; m_pe = pe; m_xe = xe; m_mp = mp; m_sl = sl;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] d, ed, keep;
    logic pb, xb;
    int nb, nst;
    checks = 0; errors = 0; done_cnt = 0; finished = 1'b0;
    rxd = 1'b1; rst_n = 1'b0;
    set_mode(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    // R9: reset state
    check("R9", "rx_data", int'(rx_data), 0);
    check("R9", "rx_xbit", int'(rx_xbit), 0);
    check("R9", "flags", int'({par_err, frm_err, rx_done}), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R1 R2 R3 R6 R8: sweep lengths, parity modes, extra bit, stop lengths
    for (int l = 0; l < 4; l++) begin
      for (int pm = 0; pm < 5; pm++) begin
        for (int x = 0; x < 2; x++) begin
          for (int k = 0; k < 3; k++) begin
            d   = 8'((k * 91 + l * 49 + pm * 7 + x * 130) & 255);
            nb  = 5 + l;
            ed  = d & 8'((1 << nb) - 1);
            xb  = logic'(k[0] ^ x[0]);
            set_mode(2'(l), 2'(pm == 0 ? 0 : pm - 1), pm != 0, x[0], 1'b0, k == 1);
            nst = (k == 1 && l != 0) ? 2 : 1;
            pb  = par_bit(m_pt, ed) ^ (k == 2);
            base = done_cnt;
            send_frame(d, nb, x[0], xb, pm != 0, pb, nst, 1'b1, 1'b1);
            send_bit(1'b1);
            expect_out("R1/R2/R3/R6", ed, x[0] & xb, (pm != 0) && (k == 2), 1'b0, 1, base);
          end
        end
      end
    end

    // R5: stop bit low, short stop
    set_mode(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    base = done_cnt;
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b1);
    send_bit(1'b1);
    expect_out("R5", 8'h3C, 1'b0, 1'b0, 1'b1, 0, base);

    // R8 / R5: second stop low in long mode, 8 bits
    set_mode(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    base = done_cnt;
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b0);
    send_bit(1'b1);
    expect_out("R8", 8'hC3, 1'b0, 1'b0, 1'b1, 0, base);

    // R8: 5 bits with long stop requested, frames back to back
    set_mode(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    base = done_cnt;
    send_frame(8'h15, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1);
    send_frame(8'h0A, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1);
    send_bit(1'b1);
    expect_out("R8", 8'h0A, 1'b0, 1'b0, 1'b0, 2, base);

    // R7: address filtering
    set_mode(2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    base = done_cnt;
    send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1);
    send_bit(1'b1);
    expect_out("R7", 8'h5A, 1'b0, 1'b0, 1'b0, 0, base);
    base = done_cnt;
    send_frame(8'hA7, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b1);
    send_bit(1'b1);
    expect_out("R7", 8'hA7, 1'b1, 1'b0, 1'b0, 1, base);
    set_mode(2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    base = done_cnt;
    send_frame(8'h81, 8, 1'b1, 1'b0, 1'b1, par_bit(2'd1, 8'h81), 1, 1'b1, 1'b1);
    send_bit(1'b1);
    expect_out("R7", 8'h81, 1'b0, 1'b0, 1'b0, 1, base);

    // R4 R10: short glitch is not a frame, outputs hold
    set_mode(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    keep = rx_data;
    base = done_cnt;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    send_bit(1'b1);
    send_bit(1'b1);
    expect_out("R4/R10", keep, 1'b0, 1'b0, 1'b0, 0, base);

    // R4: long break must not restart frames while the line stays low
    base = done_cnt;
    for (int i = 0; i < 20; i++) send_bit(1'b0);
    check("R4", "break frm_err", int'(frm_err), 1);
    check("R4", "break rx_data", int'(rx_data), 0);
    send_bit(1'b1);
    send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1);
    send_bit(1'b1);
    expect_out("R4", 8'h96, 1'b0, 1'b0, 1'b0, 1, base);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule